// File: doc/BRIEF.md
# MDIO Management Target Responder

This block is the PHY-side endpoint of a shared two-wire management bus. A master supplies the clock on MDC and sends frames on MDIO. The block follows that clock from inside its own system clock domain and parses each frame bit by bit. A frame that carries this target's strapped address either loads one of 32 sixteen-bit registers or returns the contents of one of them to the master.

Several targets hang on the same line, so the block drives MDIO only when it has to. It drives the second turnaround bit low and then shifts out the read data, using a separate output-data and output-enable pair. Any other frame, or any malformed frame, leaves the line untouched. After a rejected frame the target waits for a fresh preamble before it accepts another frame.

Top module: `mdio_target`

## Requirements
- R1: After reset the output enable is low, the output data is high, and every register holds 0x0000.
- R2: A frame with at least 32 preamble ones, start code 0,1, opcode 0,1 (write), a matching 5-bit PHY address, a 5-bit register address (both sent MSB first), turnaround and 16 data bits (MSB first) stores the data in the addressed register. The target never drives the line during a write frame.
- R3: For opcode 1,0 (read) with a matching address, the target drives 0 during the second turnaround bit and then the 16 bits of the addressed register, MSB first. The output enable is high exactly over those 17 bits and low during the earlier bits.
- R4: A frame whose PHY address differs from the strapped address leaves every register unchanged and keeps the output enable low.
- R5: A preamble of fewer than 32 ones causes the frame to be ignored. A preamble of 32 or more ones is accepted.
- R6: A frame whose start code is not 0,1 is ignored: no register changes and the output enable stays low.
- R7: Opcodes 0,0 and 1,1 cause the frame to be ignored: no register changes and the output enable stays low.
- R8: After a rejected frame, a frame sent without its own run of 32 ones is ignored.
- R9: The driven output data and output enable change only after MDC falling edges, except that the output enable drops after the rising edge of the last read data bit and before the next falling edge.
- R10: Preamble counting restarts after the last data bit of a frame, so trailing one bits of the previous frame's data do not count toward the next preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the MDC rate |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr_i | input | 5 | This target's PHY address |
| mdc_i | input | 1 | Management clock from the master |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value the target drives when enabled |
| mdio_oe_o | output | 1 | High while the target drives the data line |

## Verification
Two events share one system cycle: the rising edge of the final data bit both ends the frame and restarts the preamble count. On a read, that same edge also releases the line. The bench provokes this edge by writing 0xFFFF to a register and following it at once with a read that has only 31 preamble ones. The read must draw no response, which shows that the trailing data ones were not counted. On ordinary reads the bench checks that the enable has fallen during the high phase of the last data bit, before MDC falls again.

// File: rtl/mdio_tgt_pkg.sv
package mdio_tgt_pkg;
    localparam int DEF_REG_AW  = 5;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_PHY_AW  = 5;
    localparam int DEF_PRE_LEN = 32;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    typedef enum logic [2:0] {
        S_PRE,
        S_ST2,
        S_OP,
        S_ADDR,
        S_TA,
        S_DATA
    } fr_state_t;

    typedef struct packed {
        logic                  we;
        logic [DEF_REG_AW-1:0] addr;
        logic [DEF_DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic op_known(input logic [1:0] op);
        return (op == OP_WR) || (op == OP_RD);
    endfunction
endpackage

// File: rtl/mdio_tgt_sync.sv
module mdio_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdc_fall,
    output logic bit_o
);
    logic [STAGES:0]   mdc_sr;
    logic [STAGES-1:0] dat_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_sr <= '1;
            dat_sr <= '1;
        end else begin
            mdc_sr <= {mdc_sr[STAGES-1:0], mdc_i};
            dat_sr <= {dat_sr[STAGES-2:0], mdio_i};
        end
    end

    assign mdc_rise = mdc_sr[STAGES-1] & ~mdc_sr[STAGES];
    assign mdc_fall = ~mdc_sr[STAGES-1] & mdc_sr[STAGES];
    assign bit_o    = dat_sr[STAGES-1];
endmodule

// File: rtl/mdio_tgt_regs.sv
module mdio_tgt_regs
    import mdio_tgt_pkg::*;
#(
    parameter int REG_AW = DEF_REG_AW,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NWORDS = 1 << REG_AW;

    logic [DATA_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr.we && (wr.addr == REG_AW'(g)))
                words[g] <= wr.data;
        end
    end

    assign rd_data = words[rd_addr];

    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        wr.we |=> (words[$past(wr.addr)] == $past(wr.data)));
endmodule

// File: rtl/mdio_tgt_frame.sv
module mdio_tgt_frame
    import mdio_tgt_pkg::*;
#(
    parameter int REG_AW  = DEF_REG_AW,
    parameter int PHY_AW  = DEF_PHY_AW,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int PRE_LEN = DEF_PRE_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              bit_i,
    input  logic [PHY_AW-1:0] my_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int ADDR_BITS = PHY_AW + REG_AW;
    localparam int MAXF      = (DATA_W > ADDR_BITS) ? DATA_W : ADDR_BITS;
    localparam int CW        = $clog2(MAXF);
    localparam int PCW       = $clog2(PRE_LEN + 1);

    fr_state_t            state;
    logic [PCW-1:0]       pre_cnt;
    logic [CW-1:0]        bcnt;
    logic [1:0]           op;
    logic [ADDR_BITS-1:0] addr;
    logic [DATA_W-1:0]    shin;
    logic [DATA_W:0]      shout;
    logic                 rd_act;
    logic [ADDR_BITS-1:0] addr_nxt;
    logic [1:0]           op_nxt;

    assign addr_nxt = {addr[ADDR_BITS-2:0], bit_i};
    assign op_nxt   = {op[0], bit_i};
    assign rd_addr  = addr[REG_AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_PRE;
            pre_cnt <= '0;
            bcnt    <= '0;
            op      <= '0;
            addr    <= '0;
            shin    <= '0;
            shout   <= '1;
            rd_act  <= 1'b0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
            wr      <= '0;
        end else begin
            wr.we <= 1'b0;
            if (mdc_rise) begin
                case (state)
                    S_PRE: begin
                        if (bit_i) begin
                            if (pre_cnt != PCW'(PRE_LEN))
                                pre_cnt <= pre_cnt + 1'b1;
                        end else if (pre_cnt == PCW'(PRE_LEN)) begin
                            state <= S_ST2;
                        end else begin
                            pre_cnt <= '0;
                        end
                    end
                    S_ST2: begin
                        pre_cnt <= '0;
                        bcnt    <= '0;
                        state   <= bit_i ? S_OP : S_PRE;
                    end
                    S_OP: begin
                        op <= op_nxt;
                        if (bcnt == CW'(1)) begin
                            bcnt  <= '0;
                            state <= op_known(op_nxt) ? S_ADDR : S_PRE;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    S_ADDR: begin
                        addr <= addr_nxt;
                        if (bcnt == CW'(ADDR_BITS - 1)) begin
                            bcnt  <= '0;
                            state <= (addr_nxt[ADDR_BITS-1:REG_AW] == my_addr) ? S_TA : S_PRE;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    S_TA: begin
                        if (bcnt == '0) begin
                            bcnt <= CW'(1);
                            if (op == OP_RD) begin
                                shout  <= {1'b0, rd_data};
                                rd_act <= 1'b1;
                            end
                        end else begin
                            bcnt  <= '0;
                            state <= S_DATA;
                        end
                    end
                    S_DATA: begin
                        shin <= {shin[DATA_W-2:0], bit_i};
                        if (bcnt == CW'(DATA_W - 1)) begin
                            bcnt    <= '0;
                            state   <= S_PRE;
                            rd_act  <= 1'b0;
                            mdio_oe <= 1'b0;
                            mdio_o  <= 1'b1;
                            if (op == OP_WR) begin
                                wr.we   <= 1'b1;
                                wr.addr <= addr[REG_AW-1:0];
                                wr.data <= {shin[DATA_W-2:0], bit_i};
                            end
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    default: state <= S_PRE;
                endcase
            end else if (mdc_fall && rd_act) begin
                mdio_oe <= 1'b1;
                mdio_o  <= shout[DATA_W];
                shout   <= {shout[DATA_W-1:0], 1'b1};
            end
        end
    end

    p_oe_window_r3: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_PRE, S_ST2, S_OP, S_ADDR}) |-> !mdio_oe);

    p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!mdc_rise && !mdc_fall) |=> ($stable(mdio_o) && $stable(mdio_oe)));

    p_oe_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> $past(mdc_fall));

    p_write_op_r7: assert property (@(posedge clk) disable iff (rst)
        wr.we |-> (op == OP_WR));

    p_pre_bound_r5: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= PCW'(PRE_LEN));
endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_tgt_pkg::*;
#(
    parameter int REG_AW      = DEF_REG_AW,
    parameter int PHY_AW      = DEF_PHY_AW,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int PRE_LEN     = DEF_PRE_LEN,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHY_AW-1:0] strap_addr_i,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe_o
);
    logic              mdc_rise;
    logic              mdc_fall;
    logic              bit_s;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    wr_req_t           wr;

    mdio_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc_i    (mdc_i),
        .mdio_i   (mdio_i),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .bit_o    (bit_s)
    );

    mdio_tgt_frame #(
        .REG_AW  (REG_AW),
        .PHY_AW  (PHY_AW),
        .DATA_W  (DATA_W),
        .PRE_LEN (PRE_LEN)
    ) u_frame (
        .clk      (clk),
        .rst      (rst),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .bit_i    (bit_s),
        .my_addr  (strap_addr_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr       (wr),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe_o)
    );

    mdio_tgt_regs #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/mdio_target_tb_top.sv
module mdio_target_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mdc = 1'b0;
    logic       m_drv = 1'b1;
    logic       m_en = 1'b1;
    logic       dut_o;
    logic       dut_oe;
    logic       line;
    int         n_chk = 0;
    int         n_fail = 0;

    localparam logic [4:0] MY_ADDR = 5'h05;

    always #4 clk = ~clk;

    assign line = dut_oe ? dut_o : (m_en ? m_drv : 1'b1);

    mdio_target dut_i (
        .clk          (clk),
        .rst          (rst),
        .strap_addr_i (MY_ADDR),
        .mdc_i        (mdc),
        .mdio_i       (line),
        .mdio_o       (dut_o),
        .mdio_oe_o    (dut_oe)
    );

    // {wr, phy, reg, wdata, resp, expected}
    localparam int NV = 10;
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 5'h05, 5'h03, 16'hA5C3, 1'b0, 16'h0000},
        {1'b0, 5'h05, 5'h03, 16'h0000, 1'b1, 16'hA5C3},
        {1'b1, 5'h06, 5'h03, 16'h1111, 1'b0, 16'h0000},
        {1'b0, 5'h05, 5'h03, 16'h0000, 1'b1, 16'hA5C3},
        {1'b0, 5'h06, 5'h03, 16'h0000, 1'b0, 16'h0000},
        {1'b1, 5'h05, 5'h1F, 16'hFFFF, 1'b0, 16'h0000},
        {1'b0, 5'h05, 5'h1F, 16'h0000, 1'b1, 16'hFFFF},
        {1'b0, 5'h05, 5'h00, 16'h0000, 1'b1, 16'h0000},
        {1'b1, 5'h05, 5'h00, 16'h8001, 1'b0, 16'h0000},
        {1'b0, 5'h05, 5'h00, 16'h0000, 1'b1, 16'h8001}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, input logic drv,
                             output logic smp, output logic oe_rise,
                             output logic stable_hi, output logic oe_end);
        logic o0, oe0;
        m_drv = b;
        m_en  = drv;
        mdc   = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        smp     = line;
        oe_rise = dut_oe;
        o0      = dut_o;
        oe0     = dut_oe;
        mdc     = 1'b1;
        repeat (7) @(posedge clk);
        @(negedge clk);
        stable_hi = (dut_o == o0) && (dut_oe == oe0);
        oe_end    = dut_oe;
    endtask

    task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rd, output logic oe_any, output logic tok);
        logic s, oer, sh, oee;
        logic [13:0] hdr;
        oe_any = 1'b0;
        tok    = 1'b1;
        rd     = '0;
        hdr    = {st, op, pa, ra};
        for (int i = 0; i < pre; i++) begin
            bit_cycle(1'b1, 1'b1, s, oer, sh, oee);
            oe_any |= oer | oee;
        end
        for (int i = 13; i >= 0; i--) begin
            bit_cycle(hdr[i], 1'b1, s, oer, sh, oee);
            oe_any |= oer | oee;
        end
        // turnaround
        bit_cycle(1'b1, op == 2'b01, s, oer, sh, oee);
        oe_any |= oer | oee;
        if (oer) tok = 1'b0;
        bit_cycle(1'b0, op == 2'b01, s, oer, sh, oee);
        oe_any |= oer | oee;
        if (!(oer && s == 1'b0 && sh)) tok = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            bit_cycle(wd[i], op == 2'b01, s, oer, sh, oee);
            oe_any |= oer | oee;
            rd[i] = s;
            if (!oer) tok = 1'b0;
            if (i > 0 && !sh) tok = 1'b0;
            if (i == 0 && oee) tok = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        logic        oa, tk;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state at the ports
        chk(dut_oe == 1'b0, "R1 oe after reset", 32'(dut_oe), 0);
        chk(dut_o == 1'b1, "R1 data after reset", 32'(dut_o), 1);

        // table walk (R1 reset contents, R2, R3, R4, R9)
        for (int v = 0; v < NV; v++) begin
            logic [43:0] e;
            e = VEC[v];
            frame(32, 2'b01, e[43] ? 2'b01 : 2'b10, e[42:38], e[37:33], e[32:17], rd, oa, tk);
            if (e[43]) begin
                chk(!oa, "R2 no drive on write", 32'(oa), 0);
            end else if (e[16]) begin
                chk(oa && rd == e[15:0], "R3 read data", 32'(rd), 32'(e[15:0]));
                chk(tk, "R9 drive timing", 32'(tk), 1);
            end else begin
                chk(!oa, "R4 foreign address", 32'(oa), 0);
            end
        end

        // R5 short preamble ignored, long accepted
        frame(31, 2'b01, 2'b01, MY_ADDR, 5'h04, 16'h1234, rd, oa, tk);
        frame(32, 2'b01, 2'b10, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(oa && rd == 16'h0000, "R5 short preamble write ignored", 32'(rd), 0);
        frame(40, 2'b01, 2'b01, MY_ADDR, 5'h04, 16'hBEEF, rd, oa, tk);
        frame(40, 2'b01, 2'b10, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(oa && rd == 16'hBEEF, "R5 long preamble accepted", 32'(rd), 32'hBEEF);

        // R6 bad start code
        frame(32, 2'b00, 2'b01, MY_ADDR, 5'h04, 16'h0000, rd, oa, tk);
        frame(32, 2'b00, 2'b10, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(!oa, "R6 bad start no drive", 32'(oa), 0);
        // R8 no fresh preamble after a rejected frame
        frame(0, 2'b01, 2'b10, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(!oa, "R8 frame without preamble ignored", 32'(oa), 0);
        frame(32, 2'b01, 2'b10, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(oa && rd == 16'hBEEF, "R6 register unchanged", 32'(rd), 32'hBEEF);

        // R7 unknown opcodes
        frame(32, 2'b01, 2'b11, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(!oa, "R7 opcode 11 no drive", 32'(oa), 0);
        frame(32, 2'b01, 2'b00, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(!oa, "R7 opcode 00 no drive", 32'(oa), 0);
        frame(32, 2'b01, 2'b10, MY_ADDR, 5'h04, 16'h0, rd, oa, tk);
        chk(oa && rd == 16'hBEEF, "R7 register unchanged", 32'(rd), 32'hBEEF);

        // R10 trailing data ones do not count as preamble
        frame(32, 2'b01, 2'b01, MY_ADDR, 5'h06, 16'hFFFF, rd, oa, tk);
        frame(31, 2'b01, 2'b10, MY_ADDR, 5'h06, 16'h0, rd, oa, tk);
        chk(!oa, "R10 count restarts after frame", 32'(oa), 0);
        frame(32, 2'b01, 2'b10, MY_ADDR, 5'h06, 16'h0, rd, oa, tk);
        chk(oa && rd == 16'hFFFF, "R10 write landed", 32'(rd), 32'hFFFF);
        chk(tk, "R9 drop before next fall", 32'(tk), 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule